// File: doc/BRIEF.md
# Two-Group Set-Associative Cache Controller

This block controls a small set-associative cache whose ways are divided into a primary group and a secondary group. A configuration value sets how many of the ways count as primary; the rest are secondary. Every request first looks in the primary group. When that lookup misses, a second lookup covers the secondary group. A line missing from both groups is fetched over a simple next-level memory port. A secondary hit moves the line into the primary group. A refill also lands in the primary group. In both cases the primary line pushed out drops into the secondary group, and the secondary line pushed out by a refill is written back only when it is dirty.

A tag-mode bit selects between split tags and full tags. With split tags, the first lookup compares only the primary tags. With full tags, every tag is compared on the first lookup, so a true miss goes straight to the next level without the secondary lookup. Replacement is true LRU over all ways, wherever the primary/secondary boundary sits. The tag, data, valid, dirty and age state are held as plain registers inside the block. Only one request is handled at a time.

Address layout (word address): bits [1:0] select the word in the line, bits [5:2] select the set, and the upper bits form the tag. The next-level line address is the word address shifted right by two. Word k of a line occupies bits [32k+31:32k].

Top module: `pscache_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0. All ways are primary and split-tag mode is selected.
- R2: A primary hit responds exactly 2 cycles after the request is accepted, with `rsp_kind` = 0 and the addressed word. No next-level request is made.
- R3: A secondary hit responds 3 cycles after acceptance with `rsp_kind` = 1 and swaps the line into the primary group. A repeat access to that line is then a primary hit, and the primary line it displaced is now found as a secondary hit.
- R4: A miss in both groups issues a next-level read (`mem_req_write` = 0) of the line address. It then responds with `rsp_kind` = 2 and the refilled word. The refilled line is afterwards a primary hit.
- R5: A refill that evicts a valid dirty line first issues a next-level write (`mem_req_write` = 1) carrying that line's address and full data, and then the read. A refill that evicts a clean line issues only the read.
- R6: In split-tag mode with fewer primary than total ways, a true miss raises `mem_req_valid` 3 cycles after acceptance. In full-tag mode it is raised 2 cycles after acceptance. With all ways primary, both modes raise it after 2 cycles. In full-tag mode a line held in the secondary group is still a secondary hit.
- R7: `cfg_we` takes effect only while the block is idle, and applies from the next request onward. While busy, `cfg_we` is ignored. A primary-way count of 0 is treated as 1, and a count above the way total is treated as the total.
- R8: Replacement picks an invalid way first, otherwise the least recently used way. Every hit or refill makes the accessed line the most recently used.
- R9: A write updates the addressed word and marks the line dirty, on every outcome. The response returns the word as written.
- R10: `req_ready` is low from the acceptance cycle until the response cycle. While `mem_req_valid` is waiting for `mem_req_ready`, the request holds its address and write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load new configuration (honoured only when idle) |
| cfg_prim_ways | input | $clog2(WAYS)+1 | Number of primary ways, clamped to 1..WAYS |
| cfg_full_tags | input | 1 | 1 = compare all tags on the first lookup |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write one word |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Word read, or the word as written |
| rsp_kind | output | 2 | 0 primary hit, 1 secondary hit, 2 miss |
| mem_req_valid | output | 1 | Next-level request valid |
| mem_req_ready | input | 1 | Next-level request accepted |
| mem_req_write | output | 1 | 1 = writeback, 0 = line read |
| mem_req_addr | output | ADDR_W-$clog2(WORDS) | Line address |
| mem_req_wdata | output | WORDS*DATA_W | Writeback line data |
| mem_rsp_valid | input | 1 | Refill data valid |
| mem_rsp_data | input | WORDS*DATA_W | Refill line data |

## Verification
The assertions watch, on every cycle, the properties that can be stated locally. A response or next-level request appears only while a request is outstanding. No second request is accepted while one is in flight. A stalled next-level request stays stable. The primary-way count stays inside 1..WAYS, and the response kind is always a legal code. Only the directed scenarios can show the effects that depend on history: the line swap on a secondary hit, the choice of the LRU victim, writeback only of dirty lines, the extra lookup cycle saved by full tags, and a configuration write ignored while busy.

// File: rtl/pscache_pkg.sv
// Shared types for the two-group cache controller.
// Assumes nothing beyond the parameters of the user modules.
package pscache_pkg;
    typedef enum logic [1:0] {
        KIND_PRI  = 2'd0,
        KIND_SEC  = 2'd1,
        KIND_MISS = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRI,
        ST_SEC,
        ST_WB,
        ST_RD,
        ST_WAIT
    } state_e;
endpackage

// File: rtl/pscache_match.sv
// Tag comparator over all ways of one set.
// Assumes at most one valid way holds a given tag; the lowest matching way wins.
module pscache_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 10,
    localparam int WAYW = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            valid,
    input  logic [TAG_W-1:0]           key,
    output logic                       hit,
    output logic [WAYW-1:0]            way
);
    // Find the first valid way whose tag equals the key.
    always_comb begin
        hit = 1'b0;
        way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit && valid[w] && tags[w] == key) begin
                hit = 1'b1;
                way = WAYW'(w);
            end
        end
    end
endmodule

// File: rtl/pscache_pick.sv
// Victim picker restricted to a way mask.
// Prefers the lowest invalid way in the mask, else the oldest (largest age).
// Assumes the ages of a set form a permutation of 0..WAYS-1.
module pscache_pick #(
    parameter int WAYS = 4,
    localparam int WAYW = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAYW-1:0] ages,
    input  logic [WAYS-1:0]           valid,
    input  logic [WAYS-1:0]           mask,
    output logic [WAYW-1:0]           way
);
    logic            inv_found;
    logic            any;
    logic [WAYW-1:0] best;

    // Scan for an empty slot first, then for the least recently used one.
    always_comb begin
        way       = '0;
        inv_found = 1'b0;
        any       = 1'b0;
        best      = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (mask[w] && !valid[w] && !inv_found) begin
                inv_found = 1'b1;
                way       = WAYW'(w);
            end
        end
        if (!inv_found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (mask[w] && (!any || ages[w] > best)) begin
                    any  = 1'b1;
                    best = ages[w];
                    way  = WAYW'(w);
                end
            end
        end
    end
endmodule

// File: rtl/pscache_age.sv
// True-LRU age update: the referenced way becomes age 0 and every way
// younger than it ages by one; older ways keep their age.
// Assumes the input ages are a permutation, which the output preserves.
module pscache_age #(
    parameter int WAYS = 4,
    localparam int WAYW = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAYW-1:0] ages_in,
    input  logic [WAYW-1:0]           ref_way,
    output logic [WAYS-1:0][WAYW-1:0] ages_out
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        // Per-way next age.
        always_comb begin
            if (WAYW'(w) == ref_way)
                ages_out[w] = '0;
            else if (ages_in[w] < ages_in[ref_way])
                ages_out[w] = ages_in[w] + 1'b1;
            else
                ages_out[w] = ages_in[w];
        end
    end
endmodule

// File: rtl/pscache_ctrl.sv
// Two-group set-associative cache controller.
// Ways [0, prim) form the primary group, ways [prim, WAYS) the secondary.
// One request at a time; lookup primary, then secondary, then next level.
// Secondary hits swap with the primary LRU line; refills enter the primary
// group and push the primary LRU line into the secondary LRU slot, whose
// old line is written back when dirty. Assumes WAYS >= 2, powers of two.
module pscache_ctrl #(
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [$clog2(WAYS):0]         cfg_prim_ways,
    input  logic                          cfg_full_tags,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          rsp_valid,
    output logic [DATA_W-1:0]             rsp_rdata,
    output logic [1:0]                    rsp_kind,
    output logic                          mem_req_valid,
    input  logic                          mem_req_ready,
    output logic                          mem_req_write,
    output logic [ADDR_W-$clog2(WORDS)-1:0] mem_req_addr,
    output logic [WORDS*DATA_W-1:0]       mem_req_wdata,
    input  logic                          mem_rsp_valid,
    input  logic [WORDS*DATA_W-1:0]       mem_rsp_data
);
    import pscache_pkg::*;

    localparam int WAYW   = $clog2(WAYS);
    localparam int CNTW   = WAYW + 1;
    localparam int OFFW   = $clog2(WORDS);
    localparam int IDXW   = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFFW - IDXW;
    localparam int LINE_W = WORDS * DATA_W;

    // Storage held as plain registers.
    logic [TAG_W-1:0]              tag_q  [SETS][WAYS];
    logic [LINE_W-1:0]             data_q [SETS][WAYS];
    logic [SETS-1:0][WAYS-1:0]     valid_q;
    logic [SETS-1:0][WAYS-1:0]     dirty_q;
    logic [SETS-1:0][WAYS-1:0][WAYW-1:0] age_q;

    // Control and latched request.
    state_e            state_q;
    logic [CNTW-1:0]   p_ways_q;
    logic              full_q;
    logic              r_write;
    logic [TAG_W-1:0]  r_tag;
    logic [IDXW-1:0]   r_idx;
    logic [OFFW-1:0]   r_off;
    logic [DATA_W-1:0] r_wdata;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_rdata_q;
    kind_e             rsp_kind_q;

    // Views of the addressed set.
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0][WAYW-1:0]  set_ages;
    logic [WAYS-1:0]            set_valid, set_dirty;
    logic [WAYS-1:0]            prim_mask;
    logic                       has_sec;

    // Gather the current set and derive the group masks.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_tags[w]  = tag_q[r_idx][w];
            prim_mask[w] = CNTW'(w) < p_ways_q;
        end
        set_ages  = age_q[r_idx];
        set_valid = valid_q[r_idx];
        set_dirty = dirty_q[r_idx];
        has_sec   = p_ways_q < CNTW'(WAYS);
    end

    logic            any_hit, prim_hit;
    logic [WAYW-1:0] hit_way, pv, sv, evict;
    logic            need_wb;
    logic [WAYS-1:0][WAYW-1:0] ages_hit, ages_ev;

    pscache_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .tags(set_tags), .valid(set_valid), .key(r_tag), .hit(any_hit), .way(hit_way)
    );
    pscache_pick #(.WAYS(WAYS)) u_pick_pri (
        .ages(set_ages), .valid(set_valid), .mask(prim_mask), .way(pv)
    );
    pscache_pick #(.WAYS(WAYS)) u_pick_sec (
        .ages(set_ages), .valid(set_valid), .mask(~prim_mask), .way(sv)
    );
    pscache_age #(.WAYS(WAYS)) u_age_hit (
        .ages_in(set_ages), .ref_way(hit_way), .ages_out(ages_hit)
    );
    pscache_age #(.WAYS(WAYS)) u_age_ev (
        .ages_in(set_ages), .ref_way(evict), .ages_out(ages_ev)
    );

    // Primary-hit and eviction decisions.
    always_comb begin
        prim_hit = any_hit && prim_mask[hit_way];
        evict    = has_sec ? sv : pv;
        need_wb  = set_valid[evict] && set_dirty[evict];
    end

    logic do_pri, do_sec, do_fill;
    logic [LINE_W-1:0] base_line, final_line;

    // Commit strobes and the line after an optional word write.
    always_comb begin
        do_pri    = (state_q == ST_PRI) && prim_hit;
        do_sec    = (state_q == ST_SEC) && any_hit;
        do_fill   = (state_q == ST_WAIT) && mem_rsp_valid;
        base_line = do_fill ? mem_rsp_data : data_q[r_idx][hit_way];
        final_line = base_line;
        if (r_write)
            final_line[r_off*DATA_W +: DATA_W] = r_wdata;
    end

    // Clamp a requested primary-way count into 1..WAYS.
    function automatic logic [CNTW-1:0] clamp_ways(input logic [CNTW-1:0] v);
        if (v == '0)                return CNTW'(1);
        else if (v > CNTW'(WAYS))   return CNTW'(WAYS);
        else                        return v;
    endfunction

    // Request sequencing, configuration and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            p_ways_q    <= CNTW'(WAYS);
            full_q      <= 1'b0;
            r_write     <= 1'b0;
            r_tag       <= '0;
            r_idx       <= '0;
            r_off       <= '0;
            r_wdata     <= '0;
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
            rsp_kind_q  <= KIND_PRI;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cfg_we) begin
                        p_ways_q <= clamp_ways(cfg_prim_ways);
                        full_q   <= cfg_full_tags;
                    end
                    if (req_valid) begin
                        r_write <= req_write;
                        r_tag   <= req_addr[ADDR_W-1 -: TAG_W];
                        r_idx   <= req_addr[OFFW +: IDXW];
                        r_off   <= req_addr[OFFW-1:0];
                        r_wdata <= req_wdata;
                        state_q <= ST_PRI;
                    end
                end
                ST_PRI: begin
                    if (prim_hit) begin
                        rsp_valid_q <= 1'b1;
                        rsp_kind_q  <= KIND_PRI;
                        rsp_rdata_q <= final_line[r_off*DATA_W +: DATA_W];
                        state_q     <= ST_IDLE;
                    end else if (full_q ? any_hit : has_sec) begin
                        state_q <= ST_SEC;
                    end else begin
                        state_q <= need_wb ? ST_WB : ST_RD;
                    end
                end
                ST_SEC: begin
                    if (any_hit) begin
                        rsp_valid_q <= 1'b1;
                        rsp_kind_q  <= KIND_SEC;
                        rsp_rdata_q <= final_line[r_off*DATA_W +: DATA_W];
                        state_q     <= ST_IDLE;
                    end else begin
                        state_q <= need_wb ? ST_WB : ST_RD;
                    end
                end
                ST_WB:   if (mem_req_ready) state_q <= ST_RD;
                ST_RD:   if (mem_req_ready) state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_valid_q <= 1'b1;
                        rsp_kind_q  <= KIND_MISS;
                        rsp_rdata_q <= final_line[r_off*DATA_W +: DATA_W];
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Tag and data moves for hits, swaps and refills (no reset needed).
    always_ff @(posedge clk) begin
        if (do_pri && r_write)
            data_q[r_idx][hit_way] <= final_line;
        if (do_sec) begin
            data_q[r_idx][hit_way] <= data_q[r_idx][pv];
            tag_q[r_idx][hit_way]  <= tag_q[r_idx][pv];
            data_q[r_idx][pv]      <= final_line;
            tag_q[r_idx][pv]       <= r_tag;
        end
        if (do_fill) begin
            if (has_sec) begin
                data_q[r_idx][sv] <= data_q[r_idx][pv];
                tag_q[r_idx][sv]  <= tag_q[r_idx][pv];
            end
            data_q[r_idx][pv] <= final_line;
            tag_q[r_idx][pv]  <= r_tag;
        end
    end

    // Valid, dirty and LRU age state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAYW'(w);
        end else begin
            if (do_pri) begin
                age_q[r_idx] <= ages_hit;
                if (r_write) dirty_q[r_idx][hit_way] <= 1'b1;
            end
            if (do_sec) begin
                age_q[r_idx]              <= ages_hit;
                age_q[r_idx][pv]          <= '0;
                age_q[r_idx][hit_way]     <= ages_hit[pv];
                valid_q[r_idx][hit_way]   <= set_valid[pv];
                dirty_q[r_idx][hit_way]   <= set_dirty[pv];
                valid_q[r_idx][pv]        <= 1'b1;
                dirty_q[r_idx][pv]        <= set_dirty[hit_way] | r_write;
            end
            if (do_fill) begin
                age_q[r_idx] <= ages_ev;
                if (has_sec) begin
                    age_q[r_idx][pv]   <= '0;
                    age_q[r_idx][sv]   <= ages_ev[pv];
                    valid_q[r_idx][sv] <= set_valid[pv];
                    dirty_q[r_idx][sv] <= set_dirty[pv];
                end
                valid_q[r_idx][pv] <= 1'b1;
                dirty_q[r_idx][pv] <= r_write;
            end
        end
    end

    // Port drive.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        rsp_valid     = rsp_valid_q;
        rsp_rdata     = rsp_rdata_q;
        rsp_kind      = rsp_kind_q;
        mem_req_valid = (state_q == ST_WB) || (state_q == ST_RD);
        mem_req_write = (state_q == ST_WB);
        mem_req_addr  = (state_q == ST_WB) ? {set_tags[evict], r_idx} : {r_tag, r_idx};
        mem_req_wdata = data_q[r_idx][evict];
    end
endmodule

// File: rtl/pscache_ctrl_chk.sv
// Protocol checker for the two-group cache controller, bound to every instance.
// Tracks one outstanding request from its acceptance to its response.
module pscache_ctrl_chk #(
    parameter int WAYS    = 4,
    parameter int LADDR_W = 14
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic                    rsp_valid,
    input logic [1:0]              rsp_kind,
    input logic                    mem_req_valid,
    input logic                    mem_req_ready,
    input logic                    mem_req_write,
    input logic [LADDR_W-1:0]      mem_req_addr,
    input logic [$clog2(WAYS):0]   p_ways
);
    logic busy_q;

    // Outstanding-request tracker.
    always_ff @(posedge clk) begin
        if (!rst_n)                     busy_q <= 1'b0;
        else if (req_valid && req_ready) busy_q <= 1'b1;
        else if (rsp_valid)             busy_q <= 1'b0;
    end

    assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_mem_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    assert_rsp_only_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy_q);

    assert_mem_only_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (busy_q && !req_ready));

    assert_kind_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_kind != 2'd3));

    assert_prim_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ways != '0) && (p_ways <= ($clog2(WAYS)+1)'(WAYS)));
endmodule

bind pscache_ctrl pscache_ctrl_chk #(
    .WAYS(WAYS),
    .LADDR_W(ADDR_W - $clog2(WORDS))
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .rsp_kind(rsp_kind),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr),
    .p_ways(p_ways_q)
);

// File: tb/pscache_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench for the two-group cache controller.
module pscache_ctrl_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_prim_ways = 3'd4;
    logic         cfg_full_tags = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [15:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic [1:0]   rsp_kind;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b1;
    logic         mem_req_write;
    logic [13:0]  mem_req_addr;
    logic [127:0] mem_req_wdata;
    logic         mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_data = '0;

    int checks = 0;
    int failures = 0;

    // Results of the last request.
    logic [31:0] g_data;
    logic [1:0]  g_kind;
    int          g_lat, g_mlat;
    logic        g_mwr, g_rdy_busy;
    // Optional configuration pulse while busy.
    int          g_cfg_at = 0;
    logic [2:0]  g_cfg_p = 3'd1;
    logic        g_cfg_full = 1'b0;

    // Next-level memory model.
    logic [127:0] wmem [int];
    int           wb_count = 0;
    logic [13:0]  last_wb_addr;
    logic [127:0] last_wb_data;

    pscache_ctrl u_pscache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_prim_ways(cfg_prim_ways), .cfg_full_tags(cfg_full_tags),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_kind(rsp_kind),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    always #4 clk = ~clk;

    function automatic logic [127:0] line_of(input logic [13:0] la);
        logic [127:0] l;
        if (wmem.exists(int'(la))) return wmem[int'(la)];
        for (int k = 0; k < 4; k++) l[k*32 +: 32] = {la, 2'(k), 16'hC0DE};
        return l;
    endfunction

    function automatic logic [15:0] mk(input int tag, input int idx, input int off);
        return {10'(tag), 4'(idx), 2'(off)};
    endfunction

    function automatic logic [31:0] word_of(input logic [15:0] a);
        logic [127:0] l;
        l = line_of(a[15:2]);
        return l[a[1:0]*32 +: 32];
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory responder: logs writebacks, answers reads two cycles later.
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                if (mem_req_write) begin
                    wmem[int'(mem_req_addr)] = mem_req_wdata;
                    wb_count++;
                    last_wb_addr = mem_req_addr;
                    last_wb_data = mem_req_wdata;
                end else begin
                    logic [13:0] a;
                    a = mem_req_addr;
                    @(negedge clk);
                    @(negedge clk);
                    mem_rsp_data  = line_of(a);
                    mem_rsp_valid = 1'b1;
                end
            end
        end
    end

    // One request: latency counted in negedges after the accepting edge.
    task automatic do_req(input logic w, input logic [15:0] a, input logic [31:0] d);
        int  n;
        bit  done;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        n = 0; done = 0; g_mlat = 0; g_rdy_busy = 1'b0; g_mwr = 1'b0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
            if (n == 1) req_valid = 1'b0;
            if (g_cfg_at != 0 && n == g_cfg_at) begin
                cfg_we = 1'b1; cfg_prim_ways = g_cfg_p; cfg_full_tags = g_cfg_full;
            end else begin
                cfg_we = 1'b0;
            end
            if (mem_req_valid && g_mlat == 0) begin g_mlat = n; g_mwr = mem_req_write; end
            if (rsp_valid) begin
                done = 1; g_lat = n; g_data = rsp_rdata; g_kind = rsp_kind;
            end else if (req_ready) begin
                g_rdy_busy = 1'b1;
            end
        end
        cfg_we = 1'b0;
        g_cfg_at = 0;
    endtask

    task automatic set_cfg(input logic [2:0] p, input logic full);
        while (!req_ready) @(negedge clk);
        cfg_we = 1'b1; cfg_prim_ways = p; cfg_full_tags = full;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "req_ready", req_ready, 1);
        check("R1", "rsp_valid", rsp_valid, 0);
        check("R1", "mem_req_valid", mem_req_valid, 0);
        do_req(1'b0, mk(5, 1, 0), 32'h0);
        check("R1", "default all-primary miss request cycle", g_mlat, 2);
        check("R4", "miss kind", g_kind, 2);
        check("R4", "miss data", g_data, word_of(mk(5, 1, 0)));
        check("R10", "ready seen while busy", g_rdy_busy, 0);
        do_req(1'b0, mk(5, 1, 3), 32'h0);
        check("R2", "primary hit latency", g_lat, 2);
        check("R2", "primary hit kind", g_kind, 0);
        check("R2", "primary hit no mem request", g_mlat, 0);
        check("R4", "refilled word", g_data, word_of(mk(5, 1, 3)));
    endtask

    task automatic t_writeback();
        int wb0;
        do_req(1'b1, mk(1, 3, 1), 32'hDEAD0001);
        check("R9", "write miss returns written word", g_data, 32'hDEAD0001);
        do_req(1'b0, mk(1, 3, 1), 32'h0);
        check("R9", "written word read back", g_data, 32'hDEAD0001);
        do_req(1'b0, mk(2, 3, 0), 32'h0);
        do_req(1'b0, mk(3, 3, 0), 32'h0);
        do_req(1'b0, mk(4, 3, 0), 32'h0);
        wb0 = wb_count;
        do_req(1'b0, mk(6, 3, 2), 32'h0);
        check("R5", "dirty eviction writes first", g_mwr, 1);
        check("R5", "writeback count", wb_count - wb0, 1);
        check("R5", "writeback address", last_wb_addr, mk(1, 3, 0) >> 2);
        check("R5", "writeback word1", last_wb_data[63:32], 32'hDEAD0001);
        check("R5", "writeback word0", last_wb_data[31:0], {mk(1, 3, 0) >> 2, 2'd0, 16'hC0DE});
        check("R4", "miss after writeback data", g_data, word_of(mk(6, 3, 2)));
        wb0 = wb_count;
        do_req(1'b0, mk(7, 3, 0), 32'h0);
        check("R5", "clean eviction issues read only", g_mwr, 0);
        check("R5", "clean eviction no writeback", wb_count - wb0, 0);
    endtask

    task automatic t_lru();
        for (int t = 1; t <= 4; t++) do_req(1'b0, mk(t, 5, 0), 32'h0);
        do_req(1'b0, mk(1, 5, 0), 32'h0);
        check("R8", "refresh oldest is hit", g_kind, 0);
        do_req(1'b0, mk(9, 5, 0), 32'h0);
        do_req(1'b0, mk(1, 5, 0), 32'h0);
        check("R8", "recently used line kept", g_kind, 0);
        do_req(1'b0, mk(2, 5, 0), 32'h0);
        check("R8", "LRU line evicted", g_kind, 2);
    endtask

    task automatic t_secondary();
        set_cfg(3'd1, 1'b0);
        do_req(1'b0, mk(1, 7, 0), 32'h0);
        do_req(1'b0, mk(2, 7, 0), 32'h0);
        do_req(1'b0, mk(1, 7, 2), 32'h0);
        check("R3", "secondary hit kind", g_kind, 1);
        check("R3", "secondary hit latency", g_lat, 3);
        check("R3", "secondary hit data", g_data, word_of(mk(1, 7, 2)));
        check("R3", "secondary hit no mem request", g_mlat, 0);
        do_req(1'b0, mk(1, 7, 0), 32'h0);
        check("R3", "swapped line now primary", g_kind, 0);
        do_req(1'b0, mk(2, 7, 0), 32'h0);
        check("R3", "displaced line now secondary", g_kind, 1);
        do_req(1'b1, mk(1, 7, 3), 32'hBEEF0003);
        check("R9", "write on secondary hit kind", g_kind, 1);
        check("R9", "write on secondary hit data", g_data, 32'hBEEF0003);
        do_req(1'b0, mk(1, 7, 3), 32'h0);
        check("R9", "secondary write read back", g_data, 32'hBEEF0003);
        check("R3", "written line primary", g_kind, 0);
    endtask

    task automatic t_full();
        set_cfg(3'd1, 1'b0);
        do_req(1'b0, mk(3, 9, 0), 32'h0);
        check("R6", "split-tag miss request cycle", g_mlat, 3);
        set_cfg(3'd1, 1'b1);
        do_req(1'b0, mk(4, 9, 0), 32'h0);
        check("R6", "full-tag miss request cycle", g_mlat, 2);
        do_req(1'b0, mk(3, 9, 1), 32'h0);
        check("R6", "full-tag secondary hit kind", g_kind, 1);
        check("R6", "full-tag secondary hit data", g_data, word_of(mk(3, 9, 1)));
        set_cfg(3'd4, 1'b0);
        do_req(1'b0, mk(5, 9, 0), 32'h0);
        check("R6", "all-primary split miss cycle", g_mlat, 2);
    endtask

    task automatic t_cfg();
        set_cfg(3'd1, 1'b0);
        g_cfg_at = 1; g_cfg_p = 3'd1; g_cfg_full = 1'b1;
        do_req(1'b0, mk(1, 11, 0), 32'h0);
        do_req(1'b0, mk(2, 11, 0), 32'h0);
        check("R7", "config write while busy ignored", g_mlat, 3);
        set_cfg(3'd0, 1'b0);
        do_req(1'b0, mk(2, 7, 0), 32'h0);
        check("R7", "zero primary ways clamps to one", g_kind, 1);
        set_cfg(3'd7, 1'b0);
        do_req(1'b0, mk(1, 7, 0), 32'h0);
        check("R7", "oversize count clamps to all ways", g_kind, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_writeback();
        t_lru();
        t_secondary();
        t_full();
        t_cfg();
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule